// File: doc/BRIEF.md
# Stereo-Duplicating Serial Audio Output Shifter

This block feeds a serial audio codec running in a DSP-style frame format. At the start of each frame it takes a single parallel mono sample and serializes it twice in a row, so the left and right slots of the codec carry the same value. Serial bits change only on system clock cycles where a bit-clock falling-edge enable is high. All logic runs in the system clock domain.

A transmission starts on the first enable cycle that sees the frame-sync strobe high. The sample is captured on that edge, and its most significant bit goes out at once. Each later enable advances one bit. Once both copies have gone out, the output rests low until the next frame sync. A frame sync that arrives while a word is still being sent cuts that word short and starts the new one from its most significant bit.

Top module: `dac_ser_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `ser_o` is 0 and the block is idle until a load occurs.
- R2: On a rising clock edge where `load_i` and `shift_en_i` are both 1, `data_i` is captured and `ser_o` becomes bit 15 of that word after the same edge.
- R3: On the next 15 edges with `shift_en_i` high (and `load_i` low), `ser_o` presents the remaining bits of the captured word in MSB-first order, bit 14 down to bit 0.
- R4: On enable edges 17 to 32 of a transmission, `ser_o` repeats the same captured word again, bit 15 down to bit 0.
- R5: On the enable edge after the 32nd bit, `ser_o` goes to 0 and stays 0 on all further edges until the next load.
- R6: On an edge where `shift_en_i` is 0, `ser_o` and the bit position are unchanged, and a high `load_i` alone has no effect.
- R7: A load (both `load_i` and `shift_en_i` high) during a transmission discards the remaining bits and restarts from bit 15 of the new `data_i`.
- R8: Changes on `data_i` other than at a load edge do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Frame-sync strobe; starts a new word on an enable cycle |
| shift_en_i | input | 1 | Bit-clock falling-edge enable, one system cycle wide |
| data_i | input | 16 | Parallel mono sample |
| ser_o | output | 1 | Registered serial data to the codec |

## Verification
`ser_o` is a register, so every result is due on the rising edge where `load_i` and `shift_en_i` are sampled, and can be seen at the following falling edge. The bench applies one input set per cycle at the falling edge. It updates its reference model on the rising edge in between and compares `ser_o` at the next falling edge, so each check looks exactly one cycle after its stimulus. Random enable density, rare random loads and a new `data_i` on every cycle cover the restart, hold and capture rules. Directed runs cover the full 32-bit sequence, the idle tail and a load with no enable.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_SEND = 1'b1
  } ph_e;
endpackage

// File: rtl/dac_ser_seq.sv
module dac_ser_seq
  import dac_ser_pkg::*;
#(
  parameter int TOTAL = 32,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_en_i,
  output logic             take_o,
  output logic             adv_o,
  output logic             stop_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] nxt_idx_o
);
  ph_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last      = (cnt_q == CNT_W'(TOTAL - 1));
  assign busy_o    = (st_q == PH_SEND);
  assign take_o    = load_i & shift_en_i;
  assign adv_o     = shift_en_i & ~load_i & busy_o & ~last;
  assign stop_o    = shift_en_i & ~load_i & busy_o & last;
  assign nxt_idx_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (take_o) begin
      st_q  <= PH_SEND;
      cnt_q <= '0;
    end else if (adv_o) begin
      cnt_q <= nxt_idx_o;
    end else if (stop_o) begin
      st_q  <= PH_IDLE;
      cnt_q <= '0;
    end
  end

  // R6
  hold_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(cnt_q) && $stable(st_q));
  // R2
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && shift_en_i) |=> (cnt_q == '0) && (st_q == PH_SEND));
  // R5
  tail_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !load_i && st_q == PH_SEND && cnt_q == CNT_W'(TOTAL - 1))
      |=> (st_q == PH_IDLE));
endmodule

// File: rtl/dac_ser_bitsel.sv
module dac_ser_bitsel #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic              bit_o
);
  localparam int PW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  generate
    if ((WORD_W & (WORD_W - 1)) == 0 && CNT_W >= PW) begin : g_pow2
      // Position within a copy is the low index bits; MSB first is their complement.
      logic unused_idx;
      assign unused_idx = ^idx_i;
      assign bit_o = word_i[~idx_i[PW-1:0]];
    end else begin : g_mod
      int pos;
      always_comb pos = WORD_W - 1 - (int'(idx_i) % WORD_W);
      assign bit_o = word_i[pos];
    end
  endgenerate
endmodule

// File: rtl/dac_ser_top.sv
module dac_ser_top
  import dac_ser_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int COPIES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              ser_o
);
  localparam int TOTAL = WORD_W * COPIES;
  localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic              take, adv, stop, busy;
  logic [CNT_W-1:0]  nxt_idx;
  logic [WORD_W-1:0] word_q;
  logic              sel_bit;
  logic              ser_q;

  dac_ser_seq #(.TOTAL(TOTAL), .CNT_W(CNT_W)) seq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .shift_en_i (shift_en_i),
    .take_o     (take),
    .adv_o      (adv),
    .stop_o     (stop),
    .busy_o     (busy),
    .nxt_idx_o  (nxt_idx)
  );

  dac_ser_bitsel #(.WORD_W(WORD_W), .CNT_W(CNT_W)) sel_i (
    .word_i (word_q),
    .idx_i  (nxt_idx),
    .bit_o  (sel_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      ser_q  <= 1'b0;
    end else if (take) begin
      word_q <= data_i;
      ser_q  <= data_i[WORD_W-1];
    end else if (adv) begin
      ser_q  <= sel_bit;
    end else if (stop) begin
      ser_q  <= 1'b0;
    end
  end

  assign ser_o = ser_q;

  // R5
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !ser_o);
  // R2
  msb_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && shift_en_i) |=> (ser_o == $past(data_i[WORD_W-1])));
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(ser_o));
  // R8
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_en_i) |=> $stable(word_q));
endmodule

// File: tb/dac_ser_top_tb_top.sv
`timescale 1ns/1ps
module dac_ser_top_tb_top;
  localparam int W = 16;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] data = '0;
  logic         ser;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [W-1:0] m_word = '0;
  int           m_idx = 0;
  bit           m_act = 0;
  logic         m_out = 1'b0;
  string        m_tag = "R1";

  always #4 clk = ~clk;

  dac_ser_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .load_i     (load),
    .shift_en_i (en),
    .data_i     (data),
    .ser_o      (ser)
  );

  function automatic logic exp_bit(logic [W-1:0] w, int idx);
    return w[W - 1 - (idx % W)];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ser_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one input set at a falling edge, model the rising edge, check at the next falling edge.
  task automatic step(logic ld, logic e, logic [W-1:0] d);
    load = ld;
    en   = e;
    data = d;
    @(posedge clk);
    if (e && ld) begin
      m_tag  = m_act ? "R7" : "R2";
      m_word = d;
      m_idx  = 0;
      m_act  = 1;
      m_out  = d[W-1];
    end else if (!e) begin
      m_tag = "R6";
    end else if (m_act) begin
      if (m_idx == N - 1) begin
        m_tag = "R5";
        m_act = 0;
        m_out = 1'b0;
      end else begin
        m_idx = m_idx + 1;
        m_tag = (m_idx < W) ? "R3" : "R4";
        m_out = exp_bit(m_word, m_idx);
      end
    end else begin
      m_tag = "R5";
    end
    @(negedge clk);
    check(m_tag, ser, m_out);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run did not complete, expected end of test");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    check("R1", ser, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ser, 1'b0);
    step(1'b0, 1'b1, 16'hFFFF); // R1 idle stays low without a load

    // R2 R3 R4 R5: full dense run with data_i changing (R8)
    step(1'b1, 1'b1, 16'hA5C3);
    for (int i = 0; i < N + 6; i++) step(1'b0, 1'b1, 16'($urandom));

    // R6: load without enable is ignored
    step(1'b1, 1'b0, 16'hFFFF);
    step(1'b0, 1'b1, 16'hFFFF);

    // sparse enables across a word
    step(1'b1, 1'b1, 16'h8001);
    for (int i = 0; i < 120; i++) step(1'b0, 1'($urandom % 3 == 0), 16'($urandom));

    // R7: restart mid-transmission, in first and second copy
    step(1'b1, 1'b1, 16'h00FF);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 16'h1234);
    step(1'b1, 1'b1, 16'hF0F0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 16'h0000);
    step(1'b1, 1'b1, 16'h7FFF);
    for (int i = 0; i < N + 2; i++) step(1'b0, 1'b1, 16'hFFFF);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic e;
      e = 1'($urandom % 2);
      step(1'($urandom % 40 == 0), e, 16'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule